// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the control and status registers of a 32-bit RISC-V style core that runs at machine, supervisor and user level. On each cycle the core presents a 12-bit register address and a read strobe. It can also present a write strobe together with an operation code and an operand. The block returns the register's current contents on the same cycle. If the access is not permitted it raises an illegal-instruction flag with cause code 2. Writes take effect at the next rising clock edge.

Access rights are decoded from the address itself. Address bits [9:8] give the lowest privilege allowed to touch the register. Address bits [11:10] equal to 2'b11 mark a register that cannot be written. The three supervisor registers for status, interrupt enable and interrupt pending have no storage of their own. Each is a masked window onto the matching machine register. The delegation register for interrupts keeps only its legal bits. A free-running cycle counter and a constant-zero hart identifier are also readable.

The block performs the read-modify-write of the three register instruction forms itself: replace, set bits and clear bits. A set or clear with a zero operand is treated as a pure read.

Top module: `csr_bank`

## Requirements
- R1: While reset is asserted and right after it, every implemented register reads 0, except the ISA register at 0x301, which reads 0x40141101.
- R2: An access (read or write strobe) whose address bits [9:8] exceed cur_priv (0=user, 1=supervisor, 3=machine) sets csr_illegal, drives exc_cause to 2 and csr_rdata to 0, and changes no register.
- R3: An effective write to an address whose bits [11:10] are 2'b11 sets csr_illegal with exc_cause 2 and leaves all state unchanged. This covers the cycle counter 0xC00 and the hart identifier 0xF14.
- R4: Address 0x100 reads machine status (0x300) ANDed with 0x000DE162. A write through 0x100 changes only those bits of machine status.
- R5: Addresses 0x104 and 0x144 are windows with mask 0x222 onto 0x304 and 0x344, for both reads and writes.
- R6: A write to 0x303 stores the new value ANDed with 0x666.
- R7: Address 0xF14 always reads 0.
- R8: Address 0xC00 reads a counter that starts at 0 and advances by one on every clock edge once the internal reset has been released. The internal reset is released two rising edges after rst_n rises.
- R9: For the set-bits op (01) and the clear-bits op (10), a zero operand makes the write strobe ineffective. There is no update and no read-only trap, and the old value is still returned.
- R10: Op encoding: 00 and 11 replace the value with csr_wdata, 01 ORs csr_wdata into the value, and 10 clears the bits set in csr_wdata. Each op acts on the value seen at the accessed address.
- R11: A read and a write of the same register in one cycle return the old value. The new value is visible from the next cycle.
- R12: An address that is not implemented reads 0 and ignores writes. It raises a trap only under R2 or R3.
- R13: With csr_rd low, csr_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_op | input | 2 | Write operation: 00/11 replace, 01 set bits, 10 clear bits |
| csr_wdata | input | XLEN | Write operand |
| cur_priv | input | 2 | Current privilege level |
| csr_rdata | output | XLEN | Value read, 0 when not reading or illegal |
| csr_illegal | output | 1 | Illegal-instruction flag for this access |
| exc_cause | output | XLEN | Exception cause, 2 when illegal, else 0 |

## Verification
Two pairs of functions can land in one cycle. The first is a read together with a write of the same register. The second is a set or clear with a zero operand aimed at a read-only address, where the write suppression must win over the read-only trap. Directed probes put a read strobe and a write strobe on the same address in one cycle, and put zero-operand set and clear ops on the counter. Randomized traffic then mixes these with alias windows and privilege levels. A behavioural model kept in the bench predicts the read data, the trap flag and the cause on every clock, and judges both the same-cycle value and the value one cycle later.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int NSLOT  = 19;
  localparam int SLOT_W = $clog2(NSLOT);

  localparam logic [SLOT_W-1:0] SL_MSTATUS = 5'd0;
  localparam logic [SLOT_W-1:0] SL_MISA    = 5'd1;
  localparam logic [SLOT_W-1:0] SL_MEDELEG = 5'd2;
  localparam logic [SLOT_W-1:0] SL_MIDELEG = 5'd3;
  localparam logic [SLOT_W-1:0] SL_MIE     = 5'd4;
  localparam logic [SLOT_W-1:0] SL_MTVEC   = 5'd5;
  localparam logic [SLOT_W-1:0] SL_MSCR    = 5'd6;
  localparam logic [SLOT_W-1:0] SL_MEPC    = 5'd7;
  localparam logic [SLOT_W-1:0] SL_MCAUSE  = 5'd8;
  localparam logic [SLOT_W-1:0] SL_MTVAL   = 5'd9;
  localparam logic [SLOT_W-1:0] SL_MIP     = 5'd10;
  localparam logic [SLOT_W-1:0] SL_SEDELEG = 5'd11;
  localparam logic [SLOT_W-1:0] SL_SIDELEG = 5'd12;
  localparam logic [SLOT_W-1:0] SL_STVEC   = 5'd13;
  localparam logic [SLOT_W-1:0] SL_SSCR    = 5'd14;
  localparam logic [SLOT_W-1:0] SL_SEPC    = 5'd15;
  localparam logic [SLOT_W-1:0] SL_SCAUSE  = 5'd16;
  localparam logic [SLOT_W-1:0] SL_STVAL   = 5'd17;
  localparam logic [SLOT_W-1:0] SL_SATP    = 5'd18;

  localparam logic [31:0] MSK_FULL    = 32'hFFFF_FFFF;
  localparam logic [31:0] MSK_S_STAT  = 32'h000D_E162;
  localparam logic [31:0] MSK_S_INT   = 32'h0000_0222;
  localparam logic [31:0] MSK_DELEG   = 32'h0000_0666;
  localparam logic [31:0] ISA_RST_VAL = 32'h4014_1101;
  localparam logic [31:0] CAUSE_ILL   = 32'd2;

  typedef enum logic [1:0] {
    OPC_PUT  = 2'b00,
    OPC_OR   = 2'b01,
    OPC_ANDN = 2'b10,
    OPC_PUTX = 2'b11
  } csr_opc_e;

  typedef enum logic [1:0] {
    KD_NONE  = 2'd0,
    KD_SLOT  = 2'd1,
    KD_CYCLE = 2'd2,
    KD_ZERO  = 2'd3
  } map_kind_e;

  typedef struct packed {
    map_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [31:0]       rmask;
    logic [31:0]       wmask;
  } map_t;
endpackage

// File: rtl/csr_addr_map.sv
module csr_addr_map
  import csr_bank_pkg::*;
(
  input  logic [11:0] addr_i,
  output map_t        map_o
);
  always_comb begin
    map_o = '{kind: KD_SLOT, slot: SL_MSTATUS, rmask: MSK_FULL, wmask: MSK_FULL};
    unique case (addr_i)
      12'h300: map_o.slot = SL_MSTATUS;
      12'h100: begin
        map_o.slot  = SL_MSTATUS;
        map_o.rmask = MSK_S_STAT;
        map_o.wmask = MSK_S_STAT;
      end
      12'h301: map_o.slot = SL_MISA;
      12'h302: map_o.slot = SL_MEDELEG;
      12'h303: begin
        map_o.slot  = SL_MIDELEG;
        map_o.wmask = MSK_DELEG;
      end
      12'h304: map_o.slot = SL_MIE;
      12'h104: begin
        map_o.slot  = SL_MIE;
        map_o.rmask = MSK_S_INT;
        map_o.wmask = MSK_S_INT;
      end
      12'h305: map_o.slot = SL_MTVEC;
      12'h340: map_o.slot = SL_MSCR;
      12'h341: map_o.slot = SL_MEPC;
      12'h342: map_o.slot = SL_MCAUSE;
      12'h343: map_o.slot = SL_MTVAL;
      12'h344: map_o.slot = SL_MIP;
      12'h144: begin
        map_o.slot  = SL_MIP;
        map_o.rmask = MSK_S_INT;
        map_o.wmask = MSK_S_INT;
      end
      12'h102: map_o.slot = SL_SEDELEG;
      12'h103: map_o.slot = SL_SIDELEG;
      12'h105: map_o.slot = SL_STVEC;
      12'h140: map_o.slot = SL_SSCR;
      12'h141: map_o.slot = SL_SEPC;
      12'h142: map_o.slot = SL_SCAUSE;
      12'h143: map_o.slot = SL_STVAL;
      12'h180: map_o.slot = SL_SATP;
      12'hC00: map_o.kind = KD_CYCLE;
      12'hF14: map_o.kind = KD_ZERO;
      default: map_o.kind = KD_NONE;
    endcase
  end
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      acc_bits_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic [1:0]      priv_i,
  output logic            illegal_o,
  output logic            commit_o
);
  logic need_le;
  logic ro_addr;
  logic zero_op;
  logic wr_eff;

  always_comb begin
    need_le   = acc_bits_i[1:0] <= priv_i;
    ro_addr   = &acc_bits_i[3:2];
    zero_op   = ((op_i == 2'b01) || (op_i == 2'b10)) && (operand_i == '0);
    wr_eff    = wr_i && !zero_op;
    illegal_o = (rd_i || wr_i) && (!need_le || (wr_eff && ro_addr));
    commit_o  = wr_eff && !illegal_o;
  end
endmodule

// File: rtl/csr_cycle_ctr.sv
module csr_cycle_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CYC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_rd,
  input  logic            csr_wr,
  input  logic [1:0]      csr_op,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      cur_priv,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic [XLEN-1:0] exc_cause
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  map_t             amap;
  logic             commit;
  logic [CYC_W-1:0] cyc;
  logic [XLEN-1:0]  cyc_ext;
  logic [XLEN-1:0]  slot_q [NSLOT];
  logic [XLEN-1:0]  raw, view, newv, merged, rmask_x, wmask_x;

  csr_addr_map u_map (.addr_i(csr_addr), .map_o(amap));

  csr_priv_gate #(.XLEN(XLEN)) u_gate (
    .acc_bits_i(csr_addr[11:8]),
    .rd_i      (csr_rd),
    .wr_i      (csr_wr),
    .op_i      (csr_op),
    .operand_i (csr_wdata),
    .priv_i    (cur_priv),
    .illegal_o (csr_illegal),
    .commit_o  (commit)
  );

  csr_cycle_ctr #(.CW(CYC_W)) u_cyc (.clk(clk), .rst_n(rst_q), .cnt_o(cyc));

  always_comb begin
    cyc_ext = '0;
    cyc_ext[CYC_W-1:0] = cyc;
    rmask_x = XLEN'(amap.rmask);
    wmask_x = XLEN'(amap.wmask);
    raw     = slot_q[amap.slot];
    unique case (amap.kind)
      KD_SLOT:  view = raw & rmask_x;
      KD_CYCLE: view = cyc_ext;
      default:  view = '0;
    endcase
    unique case (csr_op)
      OPC_OR:   newv = view | csr_wdata;
      OPC_ANDN: newv = view & ~csr_wdata;
      default:  newv = csr_wdata;
    endcase
    merged    = (raw & ~wmask_x) | (newv & wmask_x);
    csr_rdata = (csr_rd && !csr_illegal) ? view : '0;
    exc_cause = csr_illegal ? XLEN'(CAUSE_ILL) : '0;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [XLEN-1:0] RST_V = (k == int'(SL_MISA)) ? XLEN'(ISA_RST_VAL) : '0;
    logic            en;
    logic [XLEN-1:0] d;

    always_comb begin
      en = commit && (amap.kind == KD_SLOT) && (amap.slot == SLOT_W'(k));
      d  = merged;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)  slot_q[k] <= RST_V;
      else if (en) slot_q[k] <= d;
    end

    AST_TRAP_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_q)
      csr_illegal |=> $stable(slot_q[k])); // R2
  end

  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_q)
    ((csr_rd || csr_wr) && (csr_addr[9:8] > cur_priv)) |-> (csr_illegal && exc_cause == XLEN'(2))); // R2

  AST_HART_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (csr_rd && csr_addr == 12'hF14) |-> (csr_rdata == '0)); // R7

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_q)
    (csr_rd && !csr_illegal && csr_addr == 12'hC00) ##1 (csr_rd && !csr_illegal && csr_addr == 12'hC00)
    |-> (csr_rdata == $past(csr_rdata) + XLEN'(1))); // R8

  AST_DELEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_q)
    (slot_q[SL_MIDELEG] & ~XLEN'(MSK_DELEG)) == '0); // R6

  AST_SSTAT_KEEP: assert property (@(posedge clk) disable iff (!rst_q)
    (commit && csr_addr == 12'h100) |=>
    ((slot_q[SL_MSTATUS] & ~XLEN'(MSK_S_STAT)) == ($past(slot_q[SL_MSTATUS]) & ~XLEN'(MSK_S_STAT)))); // R4
endmodule

// File: tb/sim_csr_bank.sv
module sim_csr_bank;
  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [11:0] a;
  logic        rd, wr;
  logic [1:0]  op, pv;
  logic [31:0] wd;
  logic [31:0] rdata, cause;
  logic        ill;

  csr_bank u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(a), .csr_rd(rd), .csr_wr(wr),
    .csr_op(op), .csr_wdata(wd), .cur_priv(pv),
    .csr_rdata(rdata), .csr_illegal(ill), .exc_cause(cause)
  );

  localparam int IMPL [19] = '{'h300, 'h301, 'h302, 'h303, 'h304, 'h305, 'h340, 'h341, 'h342,
                               'h343, 'h344, 'h102, 'h103, 'h105, 'h140, 'h141, 'h142, 'h143, 'h180};
  localparam int POOL [29] = '{'h300, 'h301, 'h302, 'h303, 'h304, 'h305, 'h340, 'h341, 'h342,
                               'h343, 'h344, 'h102, 'h103, 'h105, 'h140, 'h141, 'h142, 'h143, 'h180,
                               'h100, 'h104, 'h144, 'hC00, 'hF14, 'h7C0, 'h5A0, 'hC05, 'h000, 'hB00};

  int          checks = 0, fails = 0;
  string       cur_tag = "";
  logic [31:0] mreg [int];
  logic [31:0] mcyc;
  int          rel;
  bit          started = 0, done = 0;

  function automatic bit is_impl(int x);
    foreach (IMPL[i]) if (IMPL[i] == x) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_view(int x);
    case (x)
      'h100: return mreg['h300] & 32'h000DE162;
      'h104: return mreg['h304] & 32'h222;
      'h144: return mreg['h344] & 32'h222;
      'hC00: return mcyc;
      'hF14: return 32'h0;
      default: return is_impl(x) ? mreg[x] : 32'h0;
    endcase
  endfunction

  function automatic void m_put(int x, logic [31:0] v);
    case (x)
      'h100: mreg['h300] = (mreg['h300] & ~32'h000DE162) | (v & 32'h000DE162);
      'h104: mreg['h304] = (mreg['h304] & ~32'h222) | (v & 32'h222);
      'h144: mreg['h344] = (mreg['h344] & ~32'h222) | (v & 32'h222);
      'h303: mreg['h303] = v & 32'h666;
      default: if (is_impl(x)) mreg[x] = v;
    endcase
  endfunction

  function automatic bit m_effw();
    return wr && !(((op == 2'b01) || (op == 2'b10)) && wd == 32'h0);
  endfunction

  function automatic bit m_ill();
    return (rd || wr) && ((int'(a[9:8]) > int'(pv)) || (m_effw() && a[11:10] == 2'b11));
  endfunction

  function automatic logic [31:0] m_new(logic [31:0] old);
    case (op)
      2'b01:   return old | wd;
      2'b10:   return old & ~wd;
      default: return wd;
    endcase
  endfunction

  function automatic string tag_of(int x, bit e_ill);
    if (e_ill) return (int'(a[9:8]) > int'(pv)) ? "R2" : "R3";
    case (x)
      'h100: return "R4";
      'h104, 'h144: return "R5";
      'h303: return "R6";
      'hF14: return "R7";
      'hC00: return "R8";
      default: return is_impl(x) ? "R10" : "R12";
    endcase
  endfunction

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (IMPL[i]) mreg[IMPL[i]] = 32'h0;
      mreg['h301] = 32'h40141101;
      mcyc = 32'h0;
      rel  = 0;
    end else begin
      started = 1;
      if (rel >= 2) begin
        if (m_effw() && !m_ill()) m_put(int'(a), m_new(m_view(int'(a))));
        mcyc = mcyc + 32'd1;
      end
      if (rel < 3) rel++;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, a, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      bit          e_ill;
      logic [31:0] e_rd;
      string       t;
      e_ill = m_ill();
      e_rd  = (rd && !e_ill) ? m_view(int'(a)) : 32'h0;
      t     = (cur_tag != "") ? cur_tag : tag_of(int'(a), e_ill);
      chk(t, "illegal", {31'h0, ill}, {31'h0, e_ill});
      chk(t, "cause", cause, e_ill ? 32'd2 : 32'd0);
      chk(t, "rdata", rdata, e_rd);
    end
  end

  task automatic probe(string tag, int x, bit r, bit w, logic [1:0] o, logic [31:0] v, logic [1:0] p);
    @(posedge clk); #1;
    cur_tag = tag; a = 12'(x); rd = r; wr = w; op = o; wd = v; pv = p;
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a = '0; rd = 0; wr = 0; op = 0; wd = '0; pv = 2'd3;
    probe("R1", 'h301, 1, 0, 0, 0, 3);
    probe("R1", 'h300, 1, 0, 0, 0, 3);
    @(posedge clk); #1; rst_n = 1'b1;
    probe("R1", 'h301, 1, 0, 0, 0, 3);
    probe("R1", 'h344, 1, 0, 0, 0, 3);
    probe("R13", 'h301, 0, 0, 0, 0, 3);
    probe("R10", 'h340, 1, 1, 2'b00, 32'hA5A5_0F0F, 3);
    probe("R10", 'h340, 1, 1, 2'b01, 32'h0000_00F0, 3);
    probe("R10", 'h340, 1, 1, 2'b10, 32'h0F00_0000, 3);
    probe("R10", 'h340, 1, 1, 2'b11, 32'h1234_5678, 3);
    probe("R11", 'h341, 1, 1, 2'b00, 32'hCAFE_0001, 3);
    probe("R11", 'h341, 1, 0, 0, 0, 3);
    probe("R4", 'h300, 0, 1, 2'b00, 32'hFFFF_FFFF, 3);
    probe("R4", 'h100, 1, 1, 2'b00, 32'h0, 3);
    probe("R4", 'h300, 1, 0, 0, 0, 3);
    probe("R4", 'h100, 1, 1, 2'b01, 32'hFFFF_FFFF, 1);
    probe("R4", 'h300, 1, 0, 0, 0, 3);
    probe("R5", 'h104, 1, 1, 2'b00, 32'hFFFF_FFFF, 1);
    probe("R5", 'h304, 1, 0, 0, 0, 3);
    probe("R5", 'h344, 1, 1, 2'b00, 32'h0000_0888, 3);
    probe("R5", 'h144, 1, 1, 2'b01, 32'h0000_0FFF, 1);
    probe("R5", 'h344, 1, 0, 0, 0, 3);
    probe("R6", 'h303, 0, 1, 2'b00, 32'hFFFF_FFFF, 3);
    probe("R6", 'h303, 1, 0, 0, 0, 3);
    probe("R7", 'hF14, 1, 0, 0, 0, 3);
    probe("R3", 'hF14, 1, 1, 2'b00, 32'h5, 3);
    probe("R8", 'hC00, 1, 0, 0, 0, 0);
    probe("R8", 'hC00, 1, 0, 0, 0, 0);
    probe("R8", 'hC00, 1, 0, 0, 0, 3);
    probe("R2", 'h300, 1, 0, 0, 0, 0);
    probe("R2", 'h305, 0, 1, 2'b00, 32'hFFFF_0000, 1);
    probe("R2", 'h305, 1, 0, 0, 0, 3);
    probe("R2", 'h105, 1, 1, 2'b00, 32'h0000_0100, 1);
    probe("R3", 'hC00, 1, 1, 2'b00, 32'h1, 3);
    probe("R9", 'hC00, 1, 1, 2'b01, 32'h0, 3);
    probe("R9", 'hC00, 1, 1, 2'b10, 32'h0, 0);
    probe("R9", 'h340, 1, 1, 2'b10, 32'h0, 3);
    probe("R9", 'h340, 1, 0, 0, 0, 3);
    probe("R12", 'h7C0, 1, 1, 2'b00, 32'hDEAD_BEEF, 3);
    probe("R12", 'h7C0, 1, 0, 0, 0, 3);
    probe("R12", 'hB00, 1, 1, 2'b00, 32'h77, 3);
    probe("R3", 'hC05, 1, 1, 2'b00, 32'h77, 3);
    for (int n = 0; n < 3000; n++) begin
      int          x;
      logic [31:0] v;
      x = POOL[$urandom_range(0, 28)];
      v = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      probe("", x, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), v, 2'($urandom_range(0, 3)));
    end
    probe("", 'h301, 0, 0, 0, 0, 3);
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule